// File: doc/BRIEF.md
# Vectored Interrupt Request Manager

This block sits between the peripheral request lines of a chip and the processor's two interrupt inputs. Each of its channels picks up one request line through a programmable routing byte. A request latches into a per-channel flag, and the flag counts only while that channel's enable bit is set. A per-channel group bit places the channel in either the normal group, which drives `irq_o`, or the fast group, which drives `fiq_o`.

Within each group the lowest-numbered pending channel wins. Software reads the winner's number plus one from that group's index register, where zero means nothing is pending. That read also acknowledges the winner by clearing its latched flag.

A handler table supplies `vec_addr_o`. The table is indexed by the normal-group index value, and entry 0 serves the no-request case. Software reaches every register through a single-cycle bus with word addresses. Reads are combinational, and any side effect of a read happens on the clock edge that ends the bus cycle.

Top module: `intr_vec_mgr`

## Requirements
- R1: After reset, all enable bits are clear. Group word 0x08 reads 0x00000003 (channels 0 and 1 fast) and words 0x09 and 0x0A read 0. Both index registers read 0 and both `irq_o` and `fiq_o` are low. Routing word 0x20+w reads {8'(4w), 8'(4w+1), 8'(4w+2), 8'(4w+3)}, most significant byte first.
- R2: A write to enable-set word 0x00+b sets enable bit (c mod 32) of channel c = 32b + bit for every written 1. Bits written as 0 keep their value. Reading either word 0x00+b or word 0x04+b returns bank b of the enable bits.
- R3: A write to enable-clear word 0x04+b clears every enable bit written as 1. Writing all ones to words 0x04, 0x05 and 0x06 disables every channel, so no request reaches `irq_o`.
- R4: A channel's flag sets one cycle after its routed request line is seen high, and it stays set after the line drops. A channel is pending when its flag and its enable bit are both set. `irq_o` is high when any pending channel has group bit 0, and `fiq_o` is high when any has group bit 1. The group bit of channel 32b + i is bit i of word 0x08+b.
- R5: Word 0x0C (normal group) and word 0x0D (fast group) each return the number of the lowest-numbered pending channel of that group plus one, or 0 when that group has nothing pending.
- R6: A read of 0x0C or 0x0D clears the flag of the channel it reports. A read in the very next cycle returns 0 unless another channel is pending. A request line still held high sets the flag again one cycle later.
- R7: Routing word 0x20+w holds four 8-bit fields. Channel 4w+k uses bits [31-8k:24-8k] and follows the request line whose number is in that field. A field value of 96 or more routes no request.
- R8: Handler entry e sits at word 0x80+e and can be written and read back. `vec_addr_o`, and a read of word 0x0E, return the entry selected by the current value of word 0x0C. An index value of 96 or more selects entry 0. A read of 0x0E acknowledges nothing.
- R9: Writes to 0x0C, 0x0D and 0x0E change nothing. A read of an unassigned word returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 96 | Peripheral request lines, active high |
| bus_sel | input | 1 | Bus cycle valid this clock |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| irq_o | output | 1 | Normal-group interrupt request |
| fiq_o | output | 1 | Fast-group interrupt request |
| vec_addr_o | output | 32 | Handler address for the current normal-group winner |

## Verification
The first pattern is a single request on an enabled normal channel, read twice back to back and then once more. It separates a correct acknowledge from a missing one and from an early re-latch. The second pattern is three requests that cross a bank boundary, latched and then released. It exposes errors in priority order and in bank indexing.

A request on a disabled channel that is enabled later shows that the flag and the enable bit are kept apart. Further patterns cover a fast-group request, a group bit moved into bank 1, a remapped line that steers one channel while the original lines go quiet, and a request on the top channel. The top channel checks the fallback to handler entry 0.

// File: rtl/intr_vec_pkg.sv
package intr_vec_pkg;
    // Width of one enable / group bank and of a bus word.
    localparam int BANK_W = 32;
    // Width of one routing field inside a routing word.
    localparam int FLD_W  = 8;
    // Routing fields per routing word.
    localparam int FLD_PER_WORD = BANK_W / FLD_W;
    // Word address width of the register bus.
    localparam int AW     = 8;

    // Word address map; banked regions start at their base.
    localparam logic [AW-1:0] A_ENA_SET = 8'h00;
    localparam logic [AW-1:0] A_ENA_CLR = 8'h04;
    localparam logic [AW-1:0] A_GRP     = 8'h08;
    localparam logic [AW-1:0] A_IRQ_IDX = 8'h0C;
    localparam logic [AW-1:0] A_FIQ_IDX = 8'h0D;
    localparam logic [AW-1:0] A_VEC     = 8'h0E;
    localparam logic [AW-1:0] A_MAP     = 8'h20;
    localparam logic [AW-1:0] A_HDL     = 8'h80;
endpackage

// File: rtl/intr_req_route.sv
// Steers each channel to the request line named by its routing field.
module intr_req_route #(
    parameter int NUM_CH = 96,
    parameter int FLD_W  = 8
) (
    input  logic [NUM_CH-1:0]            req,
    input  logic [NUM_CH-1:0][FLD_W-1:0] sel,
    output logic [NUM_CH-1:0]            routed
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // Out-of-range field values route no request.
        assign routed[c] = (int'(sel[c]) < NUM_CH) ? req[sel[c]] : 1'b0;
    end
endmodule

// File: rtl/intr_prio_pick.sv
// Lowest set bit wins; output is its position plus one, zero when none.
module intr_prio_pick #(
    parameter int N     = 96,
    parameter int IDX_W = $clog2(N + 1)
) (
    input  logic [N-1:0]     vec,
    output logic [IDX_W-1:0] num
);
    always_comb begin
        num = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) num = IDX_W'(i + 1);
        end
    end
endmodule

// File: rtl/intr_vec_mgr.sv
module intr_vec_mgr
    import intr_vec_pkg::*;
#(
    parameter int NUM_CH       = 96,
    parameter int VEC_DEPTH    = 96,
    parameter int FAST_RST_CNT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_i,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              fiq_o,
    output logic [BANK_W-1:0] vec_addr_o
);
    localparam int NBANK = NUM_CH / BANK_W;
    localparam int NMAP  = NUM_CH / FLD_PER_WORD;
    localparam int IDX_W = $clog2(NUM_CH + 1);
    localparam int NGRP  = 2;   // 0: normal group, 1: fast group

    typedef struct packed {
        logic [NUM_CH-1:0]                en;
        logic [NUM_CH-1:0]                grp;
        logic [NUM_CH-1:0]                flag;
        logic [NUM_CH-1:0][FLD_W-1:0]     map;
        logic [VEC_DEPTH-1:0][BANK_W-1:0] hdl;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_CH-1:0]            routed;
    logic [NUM_CH-1:0]            pend;
    logic [NGRP-1:0][NUM_CH-1:0]  pend_grp;
    logic [NGRP-1:0][IDX_W-1:0]   win_num;
    logic [IDX_W-1:0]             irq_num;
    logic [IDX_W-1:0]             fiq_num;
    logic [NUM_CH-1:0]            en_vec;
    logic [NUM_CH-1:0]            flag_vec;
    logic [NUM_CH-1:0]            ack_mask;
    logic                         rd_irq, rd_fiq, wr_en;
    logic [BANK_W-1:0]            vec_sel;

    intr_req_route #(.NUM_CH(NUM_CH), .FLD_W(FLD_W)) route_i (
        .req    (req_i),
        .sel    (st_q.map),
        .routed (routed)
    );

    assign pend        = st_q.flag & st_q.en;
    assign pend_grp[0] = pend & ~st_q.grp;
    assign pend_grp[1] = pend & st_q.grp;

    for (genvar g = 0; g < NGRP; g++) begin : g_pick
        intr_prio_pick #(.N(NUM_CH), .IDX_W(IDX_W)) pick_i (
            .vec (pend_grp[g]),
            .num (win_num[g])
        );
    end

    assign irq_num  = win_num[0];
    assign fiq_num  = win_num[1];
    assign irq_o    = |pend_grp[0];
    assign fiq_o    = |pend_grp[1];
    assign en_vec   = st_q.en;
    assign flag_vec = st_q.flag;

    assign wr_en  = bus_sel && bus_wr;
    assign rd_irq = bus_sel && !bus_wr && (bus_addr == A_IRQ_IDX);
    assign rd_fiq = bus_sel && !bus_wr && (bus_addr == A_FIQ_IDX);

    // Vector lookup: index values past the table fall back to entry 0.
    always_comb begin
        vec_sel = st_q.hdl[0];
        for (int e = 1; e < VEC_DEPTH; e++) begin
            if (int'(irq_num) == e) vec_sel = st_q.hdl[e];
        end
    end
    assign vec_addr_o = vec_sel;

    // Next-state logic.
    always_comb begin
        st_d     = st_q;
        ack_mask = '0;
        if (rd_irq && irq_num != '0) ack_mask[irq_num - IDX_W'(1)] = 1'b1;
        if (rd_fiq && fiq_num != '0) ack_mask[fiq_num - IDX_W'(1)] = 1'b1;
        st_d.flag = (st_q.flag | routed) & ~ack_mask;

        if (wr_en) begin
            for (int b = 0; b < NBANK; b++) begin
                if (bus_addr == AW'(int'(A_ENA_SET) + b))
                    st_d.en[b*BANK_W +: BANK_W] = st_q.en[b*BANK_W +: BANK_W] | bus_wdata;
                if (bus_addr == AW'(int'(A_ENA_CLR) + b))
                    st_d.en[b*BANK_W +: BANK_W] = st_q.en[b*BANK_W +: BANK_W] & ~bus_wdata;
                if (bus_addr == AW'(int'(A_GRP) + b))
                    st_d.grp[b*BANK_W +: BANK_W] = bus_wdata;
            end
            for (int w = 0; w < NMAP; w++) begin
                if (bus_addr == AW'(int'(A_MAP) + w)) begin
                    for (int k = 0; k < FLD_PER_WORD; k++)
                        st_d.map[w*FLD_PER_WORD + k] =
                            bus_wdata[BANK_W-1-k*FLD_W -: FLD_W];
                end
            end
            for (int e = 0; e < VEC_DEPTH; e++) begin
                if (bus_addr == AW'(int'(A_HDL) + e)) st_d.hdl[e] = bus_wdata;
            end
        end
    end

    // Read data.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (bus_addr == AW'(int'(A_ENA_SET) + b) || bus_addr == AW'(int'(A_ENA_CLR) + b))
                bus_rdata = st_q.en[b*BANK_W +: BANK_W];
            if (bus_addr == AW'(int'(A_GRP) + b))
                bus_rdata = st_q.grp[b*BANK_W +: BANK_W];
        end
        if (bus_addr == A_IRQ_IDX) bus_rdata = BANK_W'(irq_num);
        if (bus_addr == A_FIQ_IDX) bus_rdata = BANK_W'(fiq_num);
        if (bus_addr == A_VEC)     bus_rdata = vec_sel;
        for (int w = 0; w < NMAP; w++) begin
            if (bus_addr == AW'(int'(A_MAP) + w)) begin
                for (int k = 0; k < FLD_PER_WORD; k++)
                    bus_rdata[BANK_W-1-k*FLD_W -: FLD_W] = st_q.map[w*FLD_PER_WORD + k];
            end
        end
        for (int e = 0; e < VEC_DEPTH; e++) begin
            if (bus_addr == AW'(int'(A_HDL) + e)) bus_rdata = st_q.hdl[e];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.en   <= '0;
            st_q.flag <= '0;
            st_q.hdl  <= '0;
            for (int c = 0; c < NUM_CH; c++) begin
                st_q.grp[c] <= (c < FAST_RST_CNT);
                st_q.map[c] <= FLD_W'(c);
            end
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/intr_vec_mgr_chk.sv
module intr_vec_mgr_chk
    import intr_vec_pkg::*;
#(
    parameter int NUM_CH = 96,
    parameter int IDX_W  = $clog2(NUM_CH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [AW-1:0]     bus_addr,
    input logic [BANK_W-1:0] bus_wdata,
    input logic [NUM_CH-1:0] en_vec,
    input logic [NUM_CH-1:0] flag_vec,
    input logic              irq_o,
    input logic              fiq_o,
    input logic [IDX_W-1:0]  irq_num,
    input logic [IDX_W-1:0]  fiq_num
);
    logic [IDX_W-1:0] acked_q;
    logic             acked_v_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acked_q   <= '0;
            acked_v_q <= 1'b0;
        end else begin
            acked_q   <= irq_num - IDX_W'(1);
            acked_v_q <= bus_sel && !bus_wr && bus_addr == A_IRQ_IDX && irq_num != '0;
        end
    end

    assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_ENA_SET)
        |=> ((en_vec[BANK_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

    assert_set_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_ENA_SET)
        |=> ((en_vec[BANK_W-1:0] & ~$past(bus_wdata)) ==
             ($past(en_vec[BANK_W-1:0]) & ~$past(bus_wdata))));

    assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_ENA_CLR)
        |=> ((en_vec[BANK_W-1:0] & $past(bus_wdata)) == '0));

    assert_irq_matches_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (irq_num != '0));

    assert_fiq_matches_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o == (fiq_num != '0));

    assert_groups_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_num != '0 && irq_num == fiq_num));

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acked_v_q |-> !flag_vec[acked_q]);
endmodule

bind intr_vec_mgr intr_vec_mgr_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .en_vec    (en_vec),
    .flag_vec  (flag_vec),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .irq_num   (irq_num),
    .fiq_num   (fiq_num)
);

// File: tb/intr_vec_mgr_tb.sv
module intr_vec_mgr_tb_top;
    localparam int NCH = 96;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] req = '0;
    logic           bus_sel = 1'b0;
    logic           bus_wr = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic           irq_o, fiq_o;
    logic [31:0]    vec_addr_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;   // 125 MHz

    intr_vec_mgr dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o), .vec_addr_o(vec_addr_o)
    );

    // Monitor: compares each bus read against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && bus_sel && !bus_wr) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty at addr %h: actual %h expected none", bus_addr, bus_rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (it.addr != bus_addr || bus_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s addr %h: actual %h expected %h", it.tag, bus_addr, bus_rdata, it.exp);
                end
            end
        end
    end

    // All tasks start and end one time unit after a rising edge.
    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
        n_chk++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s pin: actual %h expected %h", tag, act, e);
        end
    endtask

    // Pulse a set of request lines for one latching cycle.
    task automatic pulse(input logic [NCH-1:0] lines);
        req = lines;
        idle(1);
        req = '0;
    endtask

    function automatic logic [31:0] map_word(input int w);
        return {8'(4*w), 8'(4*w+1), 8'(4*w+2), 8'(4*w+3)};
    endfunction

    task automatic finish_run();
        if (sb.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [NCH-1:0] l;
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        chk({31'd0, irq_o}, 0, "R1 irq_o");
        chk({31'd0, fiq_o}, 0, "R1 fiq_o");
        rd(8'h00, 0, "R1 enable bank0");
        rd(8'h01, 0, "R1 enable bank1");
        rd(8'h02, 0, "R1 enable bank2");
        rd(8'h08, 32'h3, "R1 group bank0");
        rd(8'h09, 0, "R1 group bank1");
        rd(8'h0C, 0, "R1 irq index");
        rd(8'h0D, 0, "R1 fiq index");
        rd(8'h20, map_word(0), "R1 map word0");
        rd(8'h37, map_word(23), "R1 map word23");

        // R2 set banks
        wr(8'h00, 32'h0000_0F00);
        wr(8'h01, 32'h0000_0001);
        rd(8'h00, 32'h0000_0F00, "R2 set bank0");
        wr(8'h00, 32'h0000_0010);
        rd(8'h00, 32'h0000_0F10, "R2 zeros unchanged");
        rd(8'h04, 32'h0000_0F10, "R2 read via clear word");
        rd(8'h01, 32'h0000_0001, "R2 set bank1");

        // R3 clear one bit
        wr(8'h04, 32'h0000_0100);
        rd(8'h00, 32'h0000_0E10, "R3 clear bit8");

        // R4/R5/R6 single request, ack, re-latch
        req[9] = 1'b1;
        idle(1);
        chk({31'd0, irq_o}, 1, "R4 irq_o high");
        chk({31'd0, fiq_o}, 0, "R4 fiq_o low");
        rd(8'h0C, 10, "R5 index ch9");
        rd(8'h0C, 0, "R6 read after ack");
        rd(8'h0C, 10, "R6 level re-latch");
        req[9] = 1'b0;
        idle(1);
        rd(8'h0C, 0, "R6 drained");

        // R5 priority across banks, R4 latching and disabled channel
        l = '0; l[10] = 1; l[11] = 1; l[32] = 1; l[5] = 1;
        pulse(l);
        rd(8'h0C, 11, "R5 lowest first");
        rd(8'h0C, 12, "R5 second");
        rd(8'h0C, 33, "R5 bank1 channel");
        rd(8'h0C, 0, "R4 disabled ch5 not pending");
        wr(8'h00, 32'h0000_0020);
        rd(8'h0C, 6, "R4 latched flag after enable");
        rd(8'h0C, 0, "R6 ch5 acked");

        // R4/R5 fast group
        wr(8'h00, 32'h0000_0002);
        l = '0; l[1] = 1;
        pulse(l);
        chk({31'd0, fiq_o}, 1, "R4 fiq_o high");
        chk({31'd0, irq_o}, 0, "R4 irq_o low for fast");
        rd(8'h0C, 0, "R5 normal index empty");
        rd(8'h0D, 2, "R5 fast index ch1");
        rd(8'h0D, 0, "R6 fast ack");
        chk({31'd0, fiq_o}, 0, "R6 fiq_o after ack");
        wr(8'h09, 32'h0000_0001);
        l = '0; l[32] = 1;
        pulse(l);
        rd(8'h0C, 0, "R4 ch32 moved out of normal");
        rd(8'h0D, 33, "R4 ch32 in fast group");

        // R8 handler table
        wr(8'h80, 32'hDEAD_0000);
        wr(8'h89, 32'h1000_0900);
        rd(8'h89, 32'h1000_0900, "R8 entry readback");
        chk(vec_addr_o, 32'hDEAD_0000, "R8 phantom entry");

        // R7 routing
        wr(8'h00, 32'h0000_0100);
        wr(8'h22, 32'h46C8_0A0B);
        rd(8'h22, 32'h46C8_0A0B, "R7 map readback");
        l = '0; l[8] = 1; l[9] = 1;
        pulse(l);
        rd(8'h0C, 0, "R7 old lines no longer routed");
        l = '0; l[70] = 1;
        pulse(l);
        chk(vec_addr_o, 32'h1000_0900, "R8 vector for ch8");
        rd(8'h0E, 32'h1000_0900, "R8 vector read");
        rd(8'h0C, 9, "R7 line70 drives ch8");
        rd(8'h0C, 0, "R8 vector read did not ack");
        chk(vec_addr_o, 32'hDEAD_0000, "R8 back to phantom");

        // R8 top channel, R9 ignored writes
        wr(8'h02, 32'h8000_0000);
        l = '0; l[95] = 1;
        pulse(l);
        rd(8'h0E, 32'hDEAD_0000, "R8 index past table");
        wr(8'h0C, 32'h0000_0055);
        wr(8'h0E, 32'h1234_5678);
        rd(8'h0C, 96, "R9 write to index ignored");
        rd(8'h0C, 0, "R6 ch95 acked");
        rd(8'h0E, 32'hDEAD_0000, "R9 write to vector ignored");
        rd(8'h70, 0, "R9 unassigned word");

        // R3 disable all
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h05, 32'hFFFF_FFFF);
        wr(8'h06, 32'hFFFF_FFFF);
        rd(8'h00, 0, "R3 bank0 cleared");
        rd(8'h01, 0, "R3 bank1 cleared");
        rd(8'h02, 0, "R3 bank2 cleared");
        req[10] = 1'b1;
        idle(2);
        chk({31'd0, irq_o}, 0, "R3 no irq when disabled");
        req[10] = 1'b0;

        idle(2);
        done = 1'b1;
        finish_run();
    end
endmodule